// File: doc/BRIEF.md
# Cycle-by-Cycle H-Bridge Current Chopper

This block sits between two bridge command inputs and the four gate enables of an H-bridge. In normal operation it decodes the command pair into a bridge state and drives the matching high-side and low-side switch enables. A digital over-current input reports when the load current is above the trip level. If that input is high while a forward or reverse drive is commanded, the block forces a low-side brake (slow decay). It holds that brake until the next edge on either command input, so the external controller sets the chopping rhythm.

An active-low indicator is pulled low for as long as the forced brake lasts. It changes nothing else in the block. After every command edge, a blanking window of a set number of clocks masks the trip input so that switching transients cannot start a brake. The command inputs pass through a synchronizer, and all gate enables leave the block from registers.

Top module: `cbc_chopper`

## Requirements
- R1: The command pair {cmd_a_i, cmd_b_i} is decoded as follows. 10 is forward: high1 and low2 on. 01 is reverse: high2 and low1 on. 11 is brake: low1 and low2 on. 00 is high-impedance: all switches off.
- R2: A command change reaches the gate outputs on the third rising clock edge after the inputs change. Two of those edges are synchronizer stages and one is the output register.
- R3: If trip_i is high and unmasked while forward or reverse is commanded, the outputs switch to brake (low1 and low2 on, both high sides off) and chop_n_o goes low.
- R4: Once the forced brake is in place, it stays while the commands do not change, whatever trip_i does. A steady drive command stays braked after its first trip.
- R5: A rising or falling edge on either command input ends the forced brake. The outputs then follow the new command and chop_n_o returns high.
- R6: While the command is brake or high-impedance, trip_i has no effect: the outputs follow the command and chop_n_o stays high.
- R7: For BLANK_CYC clocks after each command edge, trip_i is ignored. After that, a trip that is still high forces the brake.
- R8: The high-side and low-side enables of the same leg are never high in the same cycle.
- R9: While rst_n is low at a clock edge, all switches are off, chop_n_o is high, and the latch and blanking window are cleared.
- R10: chop_n_o is low only while the brake is being forced over a drive command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_a_i | input | 1 | Bridge command bit A (asynchronous) |
| cmd_b_i | input | 1 | Bridge command bit B (asynchronous) |
| trip_i | input | 1 | Over-current comparator result, high = above trip level |
| hs1_o | output | 1 | Leg 1 high-side enable |
| ls1_o | output | 1 | Leg 1 low-side enable |
| hs2_o | output | 1 | Leg 2 high-side enable |
| ls2_o | output | 1 | Leg 2 low-side enable |
| chop_n_o | output | 1 | Active-low chopping indicator |

## Verification
The bench builds the block with BLANK_CYC set to 6, not the default 32. This keeps each blanking window short enough that many command edges fit in a short run. It also leaves room to sample both inside and after the window while trip_i is held high across an edge. The synchronizer stays at its two-stage default, so the three-clock command latency is checked exactly as a user would see it.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    CMD_HIZ = 2'b00,
    CMD_REV = 2'b01,
    CMD_FWD = 2'b10,
    CMD_BRK = 2'b11
  } cmd_t;

  typedef struct packed {
    logic hs1;
    logic ls1;
    logic hs2;
    logic ls2;
  } gate_t;

  localparam gate_t GATES_OFF   = '{hs1: 1'b0, ls1: 1'b0, hs2: 1'b0, ls2: 1'b0};
  localparam gate_t GATES_BRAKE = '{hs1: 1'b0, ls1: 1'b1, hs2: 1'b0, ls2: 1'b1};

  function automatic gate_t decode_cmd(input cmd_t c);
    gate_t g;
    g = GATES_OFF;
    case (c)
      CMD_FWD: begin g.hs1 = 1'b1; g.ls2 = 1'b1; end
      CMD_REV: begin g.hs2 = 1'b1; g.ls1 = 1'b1; end
      CMD_BRK: g = GATES_BRAKE;
      default: g = GATES_OFF;
    endcase
    return g;
  endfunction

  function automatic logic is_drive(input cmd_t c);
    return (c == CMD_FWD) || (c == CMD_REV);
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     raw_i,
  output chop_pkg::cmd_t cmd_o,
  output logic           edge_o
);
  import chop_pkg::*;

  logic [1:0] stage_q [STAGES];
  logic [1:0] last_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= 2'b00;
          else        stage_q[s] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= 2'b00;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 2'b00;
    else        last_q <= stage_q[STAGES-1];
  end

  assign cmd_o  = cmd_t'(stage_q[STAGES-1]);
  assign edge_o = (stage_q[STAGES-1] != last_q);

endmodule

// File: rtl/chop_blank.sv
module chop_blank #(
  parameter int BLANK_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic active_o
);
  localparam int CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (edge_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = edge_i || (cnt_q != '0);

endmodule

// File: rtl/chop_latch.sv
module chop_latch (
  input  logic           clk,
  input  logic           rst_n,
  input  chop_pkg::cmd_t cmd_i,
  input  logic           edge_i,
  input  logic           blank_i,
  input  logic           trip_i,
  output logic           drive_o,
  output logic           trip_ok_o,
  output chop_pkg::gate_t gates_o,
  output logic           chop_n_o
);
  import chop_pkg::*;

  logic  chop_q;
  logic  chop_d;
  gate_t gates_d;

  assign drive_o   = is_drive(cmd_i);
  assign trip_ok_o = trip_i && !blank_i;

  always_comb begin
    if (edge_i)                      chop_d = 1'b0;
    else if (trip_ok_o && drive_o)   chop_d = 1'b1;
    else                             chop_d = chop_q;
    gates_d = chop_d ? GATES_BRAKE : decode_cmd(cmd_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chop_q   <= 1'b0;
      gates_o  <= GATES_OFF;
      chop_n_o <= 1'b1;
    end else begin
      chop_q   <= chop_d;
      gates_o  <= gates_d;
      chop_n_o <= !chop_d;
    end
  end

endmodule

// File: rtl/cbc_chopper.sv
module cbc_chopper #(
  parameter int BLANK_CYC   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_a_i,
  input  logic cmd_b_i,
  input  logic trip_i,
  output logic hs1_o,
  output logic ls1_o,
  output logic hs2_o,
  output logic ls2_o,
  output logic chop_n_o
);
  import chop_pkg::*;

  cmd_t  cmd_w;
  logic  edge_w;
  logic  blank_w;
  logic  drive_w;
  logic  trip_ok_w;
  gate_t gates_w;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({cmd_a_i, cmd_b_i}),
    .cmd_o  (cmd_w),
    .edge_o (edge_w)
  );

  chop_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (edge_w),
    .active_o (blank_w)
  );

  chop_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd_w),
    .edge_i    (edge_w),
    .blank_i   (blank_w),
    .trip_i    (trip_i),
    .drive_o   (drive_w),
    .trip_ok_o (trip_ok_w),
    .gates_o   (gates_w),
    .chop_n_o  (chop_n_o)
  );

  assign hs1_o = gates_w.hs1;
  assign ls1_o = gates_w.ls1;
  assign hs2_o = gates_w.hs2;
  assign ls2_o = gates_w.ls2;

endmodule

// File: rtl/cbc_chopper_chk.sv
module cbc_chopper_chk (
  input logic clk,
  input logic rst_n,
  input logic hs1,
  input logic ls1,
  input logic hs2,
  input logic ls2,
  input logic chop_n,
  input logic edge_w,
  input logic blank_w,
  input logic drive_w,
  input logic trip_ok_w
);

  assert_no_shoot_through_R8: assert property (@(posedge clk)
    !(hs1 && ls1) && !(hs2 && ls2));

  assert_reset_clears_R9: assert property (@(posedge clk)
    !rst_n |=> (!hs1 && !ls1 && !hs2 && !ls2 && chop_n));

  assert_chop_means_brake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chop_n |-> (ls1 && ls2 && !hs1 && !hs2));

  assert_trip_brakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_ok_w && drive_w && !edge_w) |=> !chop_n);

  assert_hold_until_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chop_n && !edge_w) |=> !chop_n);

  assert_edge_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> chop_n);

  assert_blank_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_w && chop_n) |=> chop_n);

  assert_only_in_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_w && chop_n) |=> chop_n);

endmodule

bind cbc_chopper cbc_chopper_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs1       (hs1_o),
  .ls1       (ls1_o),
  .hs2       (hs2_o),
  .ls2       (ls2_o),
  .chop_n    (chop_n_o),
  .edge_w    (edge_w),
  .blank_w   (blank_w),
  .drive_w   (drive_w),
  .trip_ok_w (trip_ok_w)
);

// File: tb/cbc_chopper_test.sv
module cbc_chopper_test;

  localparam int BLANK = 6;
  localparam logic [3:0] G_FWD = 4'b1001;
  localparam logic [3:0] G_REV = 4'b0110;
  localparam logic [3:0] G_BRK = 4'b0101;
  localparam logic [3:0] G_OFF = 4'b0000;

  // vector: {a, b, trip, expected gates {hs1,ls1,hs2,ls2}, expected chop_n}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, G_BRK, 1'b0},
    {1'b0, 1'b1, 1'b1, G_BRK, 1'b0},
    {1'b1, 1'b1, 1'b1, G_BRK, 1'b1},
    {1'b0, 1'b0, 1'b1, G_OFF, 1'b1},
    {1'b1, 1'b0, 1'b0, G_FWD, 1'b1},
    {1'b0, 1'b1, 1'b0, G_REV, 1'b1},
    {1'b0, 1'b0, 1'b0, G_OFF, 1'b1},
    {1'b1, 1'b1, 1'b0, G_BRK, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0, trip = 1'b0;
  logic hs1, ls1, hs2, ls2, chop_n;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  cbc_chopper #(.BLANK_CYC(BLANK)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_a_i(a), .cmd_b_i(b), .trip_i(trip),
    .hs1_o(hs1), .ls1_o(ls1), .hs2_o(hs2), .ls2_o(ls2), .chop_n_o(chop_n)
  );

  function automatic logic [3:0] pass_gates(input logic ia, input logic ib);
    case ({ia, ib})
      2'b10:   return G_FWD;
      2'b01:   return G_REV;
      2'b11:   return G_BRK;
      default: return G_OFF;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] eg, input logic en);
    logic [3:0] g;
    g = {hs1, ls1, hs2, ls2};
    n_chk++;
    if (g !== eg || chop_n !== en) begin
      n_fail++;
      $display("FAIL %s: gates=%b chop_n=%b expected gates=%b chop_n=%b",
               req, g, chop_n, eg, en);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(input logic ia, input logic ib, input logic t);
    @(negedge clk);
    a = ia; b = ib; trip = t;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=expired expected=done");
    finish_run();
  end

  initial begin
    // R9: reset state
    wait_n(3);
    check("R9 reset", G_OFF, 1'b1);
    rst_n = 1'b1;
    wait_n(2);

    // R2: latency of exactly three edges
    apply(1'b1, 1'b0, 1'b0);
    wait_n(2);
    check("R2 before third edge", G_OFF, 1'b1);
    wait_n(1);
    check("R2 after third edge", G_FWD, 1'b1);
    wait_n(BLANK + 4);

    // Table walk: R1, R3, R5, R6, R4
    for (int i = 0; i < NV; i++) begin
      logic va, vb, vt, ven;
      logic [3:0] veg;
      {va, vb, vt, veg, ven} = VEC[i];
      apply(va, vb, 1'b0);
      wait_n(BLANK + 8);
      check("R1/R5 pass-through after edge", pass_gates(va, vb), 1'b1);
      trip = vt;
      wait_n(3);
      check(vt ? (ven ? "R6 trip ignored" : "R3 trip brakes") : "R1 decode", veg, ven);
      trip = 1'b0;
      wait_n(3);
      check("R4 state held after trip drops", veg, ven);
    end

    // R4: steady drive stays braked after one trip pulse
    apply(1'b0, 1'b1, 1'b0);
    wait_n(BLANK + 8);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    wait_n(50);
    check("R4 full-duty stays braked", G_BRK, 1'b0);

    // R5: single-input falling edge releases (01 -> 00)
    apply(1'b0, 1'b0, 1'b0);
    wait_n(4);
    check("R5 release on falling edge", G_OFF, 1'b1);

    // R7: blanking masks a held trip after an edge
    apply(1'b1, 1'b0, 1'b1);
    wait_n(4);
    check("R7 inside blanking", G_FWD, 1'b1);
    wait_n(BLANK + 4);
    check("R7 after blanking", G_BRK, 1'b0);

    // R5 + R7: edge while chopped with trip still high
    apply(1'b0, 1'b1, 1'b1);
    wait_n(4);
    check("R5 release with trip held", G_REV, 1'b1);
    wait_n(BLANK + 4);
    check("R7 re-brake after window", G_BRK, 1'b0);

    // R6: drive to slow decay with trip held, indicator stays released
    apply(1'b1, 1'b1, 1'b1);
    wait_n(BLANK + 10);
    check("R6 slow decay ignores trip", G_BRK, 1'b1);

    // R9: reset while chopped
    apply(1'b1, 1'b0, 1'b0);
    wait_n(BLANK + 8);
    trip = 1'b1;
    wait_n(3);
    check("R3 chopped before reset", G_BRK, 1'b0);
    rst_n = 1'b0;
    wait_n(2);
    check("R9 reset mid-chop", G_OFF, 1'b1);
    trip = 1'b0;
    rst_n = 1'b1;
    wait_n(4);
    check("R2 follows after reset", G_FWD, 1'b1);

    finish_run();
  end

endmodule